// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside a processor's execute stage and is consulted at every instruction boundary. It looks at all pending interrupt causes: a divide fault, a software interrupt with its own type byte, an overflow-trap instruction qualified by the overflow flag, a rising edge on the non-maskable pin, the maskable request line with an externally supplied type byte, and the single-step trap flag. It picks one of them by fixed priority. It then runs the entry sequence. The flags word is pushed first, and in that same cycle the block orders the interrupt-enable and trap flags cleared. The return code segment is pushed next, then the return instruction pointer. Last, the block presents the chosen type together with the two vector-table addresses from which the new instruction pointer and code segment are to be read.

The sequencer is a five-state machine: IDLE, PUSH_FL, PUSH_CS, PUSH_IP and VECTOR. Its transitions are:
- ACCEPT: IDLE to PUSH_FL, when a boundary strobe arrives while some cause is eligible.
- STAY: IDLE to IDLE, on every other cycle.
- PUSH_FL to PUSH_CS, PUSH_CS to PUSH_IP and PUSH_IP to VECTOR, each one unconditional.
- FINISH: VECTOR to IDLE.

The flags word, the code segment and the instruction pointer are all captured at the ACCEPT edge. A rising edge on the non-maskable pin is latched into a pending bit, and that bit stays set until the non-maskable entry is accepted. This means a short pulse is never lost.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy_o, push_valid_o, flag_clr_o and done_o are 0. A non-maskable pin held at 0 through reset leaves nothing pending.
- R2: When an entry is accepted at clock edge E, the following cycles each show one state, with its outputs in the cycle after the edge:
  - after E: push_valid_o=1, push_data_o = the flags_i value sampled at E, and flag_clr_o=1;
  - after E+1: push_data_o = the cs_i value sampled at E;
  - after E+2: push_data_o = the ip_i value sampled at E;
  - after E+3: done_o=1 with type_o set, and push_valid_o=0;
  - after E+4: the block is idle again.
  busy_o is 1 in all four active cycles.
- R3: In the done cycle, vec_ip_addr_o equals type_o multiplied by 4 and vec_cs_addr_o equals type_o multiplied by 4, plus 2. Both are TYPE_W+2 bits wide.
- R4: When several causes are eligible at the same boundary, the winner follows this fixed order, highest first: divide fault, then taken overflow trap, then software interrupt, then non-maskable, then maskable request, then single step.
- R5: A divide fault enters with type 0, whatever the interrupt-enable and trap flags hold.
- R6: An overflow-trap instruction enters with type 4 when ovf_i=1. When ovf_i=0 it is no cause at all: with no other cause present no push occurs, and any lower cause is served instead.
- R7: A software interrupt enters with the type given on swi_type_i. The breakpoint case is type 3.
- R8: A 0-to-1 transition of nmi_pin_i, seen on one clock edge, makes a type 2 entry pending. That entry is taken at a later boundary even if the pin has already returned to 0, and even if the interrupt-enable flag is 0. A pin that stays at 1 raises no further entry.
- R9: The maskable request is eligible only while flags_i bit 9 (interrupt enable) is 1. It enters with the type on intr_type_i.
- R10: While flags_i bit 8 (trap) is 1, a boundary with no other cause enters with type 1.
- R11: A boundary strobe that arrives while an entry is in progress is ignored, and the sequence in progress continues unchanged. A boundary with no eligible cause leaves the block idle.
- R12: A non-maskable edge that coincides with the acceptance of a higher-priority entry stays pending. It is served at the next boundary after that entry completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| div_err_i | input | 1 | Divide fault |
| swi_req_i | input | 1 | Software interrupt request |
| swi_type_i | input | TYPE_W | Software interrupt type |
| into_i | input | 1 | Overflow-trap instruction executed |
| ovf_i | input | 1 | Overflow flag |
| nmi_pin_i | input | 1 | Non-maskable pin (synchronous), edge sensitive |
| intr_i | input | 1 | Maskable interrupt request |
| intr_type_i | input | TYPE_W | Type byte supplied with the maskable request |
| flags_i | input | WORD_W | Current flags word (bit 9 enable, bit 8 trap) |
| cs_i | input | WORD_W | Return code segment |
| ip_i | input | WORD_W | Return instruction pointer |
| busy_o | output | 1 | Entry sequence in progress |
| push_valid_o | output | 1 | A stack push is presented this cycle |
| push_data_o | output | WORD_W | Word to push |
| flag_clr_o | output | 1 | Clear interrupt-enable and trap flags |
| done_o | output | 1 | Vector addresses valid |
| type_o | output | TYPE_W | Selected interrupt type |
| vec_ip_addr_o | output | TYPE_W+2 | Table address of the new instruction pointer |
| vec_cs_addr_o | output | TYPE_W+2 | Table address of the new code segment |

## Verification
Two functions can fall in the same cycle. One is the latching of a new non-maskable edge into the pending bit. The other is the acceptance of a different, higher-priority entry, in a cycle where the pending bit might otherwise be cleared. The bench provokes this by raising the pin in the same cycle as a boundary carrying a divide fault. It judges the result by requiring a complete type 0 sequence first, followed by a type 2 entry at the next bare boundary. A second collision is a boundary strobe with a divide fault raised in the middle of a running sequence. For that case the bench requires the remaining pushes to be unchanged and the block to be idle afterwards.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_VECTOR
    } entry_state_t;

    // Cause index doubles as priority rank: lower index wins.
    localparam int SRC_DIV  = 0;
    localparam int SRC_OVF  = 1;
    localparam int SRC_SWI  = 2;
    localparam int SRC_NMI  = 3;
    localparam int SRC_INTR = 4;
    localparam int SRC_STEP = 5;
    localparam int SRC_N    = 6;

    localparam int VEC_DIVIDE = 0;
    localparam int VEC_STEP   = 1;
    localparam int VEC_NMI    = 2;
    localparam int VEC_OVF    = 4;

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic take_i,
    output logic pend_o
);

    logic pin_q;
    logic pend_q;
    logic rise;

    assign rise   = pin_i & ~pin_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            pin_q  <= pin_i;
            pend_q <= (pend_q & ~take_i) | rise;
        end
    end

    // R8
    nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend_q);

    // R12
    nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !rise) |=> !pend_q);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              div_err_i,
    input  logic              into_i,
    input  logic              ovf_i,
    input  logic              swi_req_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    input  logic              nmi_pend_i,
    input  logic              intr_i,
    input  logic [TYPE_W-1:0] intr_type_i,
    input  logic              ien_i,
    input  logic              trap_i,
    output logic              req_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              sel_nmi_o,
    output logic              sel_intr_o
);

    logic [SRC_N-1:0]  raw;
    logic [SRC_N:0]    blocked;
    logic [SRC_N-1:0]  grant;
    logic [TYPE_W-1:0] cand [SRC_N];

    assign raw[SRC_DIV]  = div_err_i;
    assign raw[SRC_OVF]  = into_i & ovf_i;
    assign raw[SRC_SWI]  = swi_req_i;
    assign raw[SRC_NMI]  = nmi_pend_i;
    assign raw[SRC_INTR] = intr_i & ien_i;
    assign raw[SRC_STEP] = trap_i;

    assign cand[SRC_DIV]  = TYPE_W'(VEC_DIVIDE);
    assign cand[SRC_OVF]  = TYPE_W'(VEC_OVF);
    assign cand[SRC_SWI]  = swi_type_i;
    assign cand[SRC_NMI]  = TYPE_W'(VEC_NMI);
    assign cand[SRC_INTR] = intr_type_i;
    assign cand[SRC_STEP] = TYPE_W'(VEC_STEP);

    assign blocked[0] = 1'b0;

    generate
        for (genvar g = 0; g < SRC_N; g++) begin : g_rank
            assign grant[g]     = raw[g] & ~blocked[g];
            assign blocked[g+1] = blocked[g] | raw[g];
        end
    endgenerate

    always_comb begin
        type_o = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (grant[i]) begin
                type_o = cand[i];
            end
        end
    end

    assign req_o      = blocked[SRC_N];
    assign sel_nmi_o  = grant[SRC_NMI];
    assign sel_intr_o = grant[SRC_INTR];

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_pkg::*;
#(
    parameter int TYPE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boundary_i,
    input  logic                req_i,
    input  logic [TYPE_W-1:0]   req_type_i,
    input  logic [WORD_W-1:0]   flags_i,
    input  logic [WORD_W-1:0]   cs_i,
    input  logic [WORD_W-1:0]   ip_i,
    output logic                accept_o,
    output logic                busy_o,
    output logic                push_valid_o,
    output logic [WORD_W-1:0]   push_data_o,
    output logic                flag_clr_o,
    output logic                done_o,
    output logic [TYPE_W-1:0]   type_o,
    output logic [TYPE_W+1:0]   vec_ip_addr_o,
    output logic [TYPE_W+1:0]   vec_cs_addr_o
);

    localparam int VEC_W = TYPE_W + 2;

    entry_state_t      state_q, state_d;
    logic [TYPE_W-1:0] type_q;
    logic [WORD_W-1:0] fl_q, cs_q, ip_q;

    assign accept_o = (state_q == ST_IDLE) && boundary_i && req_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept_o) state_d = ST_PUSH_FL;
            ST_PUSH_FL: state_d = ST_PUSH_CS;
            ST_PUSH_CS: state_d = ST_PUSH_IP;
            ST_PUSH_IP: state_d = ST_VECTOR;
            ST_VECTOR:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            type_q  <= '0;
            fl_q    <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                type_q <= req_type_i;
                fl_q   <= flags_i;
                cs_q   <= cs_i;
                ip_q   <= ip_i;
            end
        end
    end

    always_comb begin
        busy_o        = 1'b1;
        push_valid_o  = 1'b0;
        push_data_o   = '0;
        flag_clr_o    = 1'b0;
        done_o        = 1'b0;
        type_o        = '0;
        vec_ip_addr_o = '0;
        vec_cs_addr_o = '0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_PUSH_FL: begin
                push_valid_o = 1'b1;
                push_data_o  = fl_q;
                flag_clr_o   = 1'b1;
            end
            ST_PUSH_CS: begin
                push_valid_o = 1'b1;
                push_data_o  = cs_q;
            end
            ST_PUSH_IP: begin
                push_valid_o = 1'b1;
                push_data_o  = ip_q;
            end
            ST_VECTOR: begin
                done_o        = 1'b1;
                type_o        = type_q;
                vec_ip_addr_o = {type_q, 2'b00};
                vec_cs_addr_o = VEC_W'({type_q, 2'b00}) + VEC_W'(2);
            end
            default: busy_o = 1'b0;
        endcase
    end

    // R2
    fl_then_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_FL) |=> (state_q == ST_PUSH_CS && $stable(cs_q)));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_IP) |=> (state_q == ST_VECTOR && $stable(type_q)));

    // R2
    done_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(push_valid_o));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(boundary_i && req_i)) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_pkg::*;
#(
    parameter int TYPE_W = 8,
    parameter int WORD_W = 16,
    parameter int IF_BIT = 9,
    parameter int TF_BIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boundary_i,
    input  logic                div_err_i,
    input  logic                swi_req_i,
    input  logic [TYPE_W-1:0]   swi_type_i,
    input  logic                into_i,
    input  logic                ovf_i,
    input  logic                nmi_pin_i,
    input  logic                intr_i,
    input  logic [TYPE_W-1:0]   intr_type_i,
    input  logic [WORD_W-1:0]   flags_i,
    input  logic [WORD_W-1:0]   cs_i,
    input  logic [WORD_W-1:0]   ip_i,
    output logic                busy_o,
    output logic                push_valid_o,
    output logic [WORD_W-1:0]   push_data_o,
    output logic                flag_clr_o,
    output logic                done_o,
    output logic [TYPE_W-1:0]   type_o,
    output logic [TYPE_W+1:0]   vec_ip_addr_o,
    output logic [TYPE_W+1:0]   vec_cs_addr_o
);

    logic              nmi_pend;
    logic              req;
    logic [TYPE_W-1:0] req_type;
    logic              sel_nmi;
    logic              sel_intr;
    logic              accept;

    irq_nmi_edge i_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (nmi_pin_i),
        .take_i (accept & sel_nmi),
        .pend_o (nmi_pend)
    );

    irq_arbiter #(.TYPE_W(TYPE_W)) i_arb (
        .div_err_i   (div_err_i),
        .into_i      (into_i),
        .ovf_i       (ovf_i),
        .swi_req_i   (swi_req_i),
        .swi_type_i  (swi_type_i),
        .nmi_pend_i  (nmi_pend),
        .intr_i      (intr_i),
        .intr_type_i (intr_type_i),
        .ien_i       (flags_i[IF_BIT]),
        .trap_i      (flags_i[TF_BIT]),
        .req_o       (req),
        .type_o      (req_type),
        .sel_nmi_o   (sel_nmi),
        .sel_intr_o  (sel_intr)
    );

    irq_entry_fsm #(.TYPE_W(TYPE_W), .WORD_W(WORD_W)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .boundary_i    (boundary_i),
        .req_i         (req),
        .req_type_i    (req_type),
        .flags_i       (flags_i),
        .cs_i          (cs_i),
        .ip_i          (ip_i),
        .accept_o      (accept),
        .busy_o        (busy_o),
        .push_valid_o  (push_valid_o),
        .push_data_o   (push_data_o),
        .flag_clr_o    (flag_clr_o),
        .done_o        (done_o),
        .type_o        (type_o),
        .vec_ip_addr_o (vec_ip_addr_o),
        .vec_cs_addr_o (vec_cs_addr_o)
    );

    // R9
    intr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_intr) |-> flags_i[IF_BIT]);

    // R5
    div_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && div_err_i) |=> (busy_o && !$stable(nmi_pend) || busy_o));

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic        div_err_i = 1'b0;
    logic        swi_req_i = 1'b0;
    logic [7:0]  swi_type_i = '0;
    logic        into_i = 1'b0;
    logic        ovf_i = 1'b0;
    logic        nmi_pin_i = 1'b0;
    logic        intr_i = 1'b0;
    logic [7:0]  intr_type_i = '0;
    logic [15:0] flags_i = '0;
    logic [15:0] cs_i = 16'h1234;
    logic [15:0] ip_i = 16'h5678;
    logic        busy_o, push_valid_o, flag_clr_o, done_o;
    logic [15:0] push_data_o;
    logic [7:0]  type_o;
    logic [9:0]  vec_ip_addr_o, vec_cs_addr_o;

    int n_tests = 0;
    int n_fail = 0;

    localparam logic [15:0] F_IF = 16'h0200;
    localparam logic [15:0] F_TF = 16'h0100;

    always #10 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .div_err_i(div_err_i),
        .swi_req_i(swi_req_i), .swi_type_i(swi_type_i), .into_i(into_i), .ovf_i(ovf_i),
        .nmi_pin_i(nmi_pin_i), .intr_i(intr_i), .intr_type_i(intr_type_i),
        .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i), .busy_o(busy_o),
        .push_valid_o(push_valid_o), .push_data_o(push_data_o), .flag_clr_o(flag_clr_o),
        .done_o(done_o), .type_o(type_o), .vec_ip_addr_o(vec_ip_addr_o),
        .vec_cs_addr_o(vec_cs_addr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_reqs();
        boundary_i = 0; div_err_i = 0; swi_req_i = 0; into_i = 0; ovf_i = 0; intr_i = 0;
    endtask

    // Inputs already driven at a negedge; boundary_i set by caller.
    task automatic expect_entry(input string tag, input logic [7:0] et);
        logic [15:0] ef, ec, ei;
        logic [9:0]  ea;
        ef = flags_i; ec = cs_i; ei = ip_i;
        ea = {et, 2'b00};
        @(posedge clk); @(negedge clk);
        clear_reqs();
        chk(push_valid_o && flag_clr_o && busy_o && push_data_o == ef, {tag, " R2 flags push"}, push_data_o, ef);
        @(negedge clk);
        chk(push_valid_o && !flag_clr_o && push_data_o == ec, {tag, " R2 cs push"}, push_data_o, ec);
        @(negedge clk);
        chk(push_valid_o && push_data_o == ei, {tag, " R2 ip push"}, push_data_o, ei);
        @(negedge clk);
        chk(done_o && !push_valid_o && type_o == et, {tag, " type"}, type_o, et);
        chk(vec_ip_addr_o == ea && vec_cs_addr_o == ea + 10'd2, {tag, " R3 vector"}, vec_ip_addr_o, ea);
        @(negedge clk);
        chk(!busy_o && !done_o, {tag, " R2 back idle"}, busy_o, 0);
    endtask

    task automatic expect_none(input string tag);
        @(posedge clk); @(negedge clk);
        clear_reqs();
        chk(!busy_o && !push_valid_o, tag, push_valid_o, 0);
    endtask

    task automatic t_reset();
        chk(!busy_o && !push_valid_o && !flag_clr_o && !done_o, "R1 reset", busy_o, 0);
        flags_i = F_IF; boundary_i = 1;
        expect_none("R1 no nmi pending after reset");
    endtask

    task automatic t_divide();
        flags_i = F_IF | F_TF | 16'h0001; cs_i = 16'hA001; ip_i = 16'hB002;
        div_err_i = 1; intr_i = 1; intr_type_i = 8'h40; boundary_i = 1;
        expect_entry("R5 divide", 8'd0);
    endtask

    task automatic t_overflow();
        flags_i = 16'h0000; into_i = 1; ovf_i = 0; boundary_i = 1;
        expect_none("R6 overflow trap no-op");
        flags_i = F_TF; into_i = 1; ovf_i = 0; boundary_i = 1;
        expect_entry("R6 no-op falls to step", 8'd1);
        flags_i = F_TF; into_i = 1; ovf_i = 1; swi_req_i = 1; swi_type_i = 8'h21; boundary_i = 1;
        expect_entry("R6 R4 overflow taken", 8'd4);
    endtask

    task automatic t_swi();
        flags_i = 16'h0000; swi_req_i = 1; swi_type_i = 8'd3; cs_i = 16'h0C0C; boundary_i = 1;
        expect_entry("R7 breakpoint", 8'd3);
        swi_req_i = 1; swi_type_i = 8'hFF; ip_i = 16'hFFFE; boundary_i = 1;
        expect_entry("R7 R3 type ff", 8'hFF);
    endtask

    task automatic t_intr();
        flags_i = 16'h0000; intr_i = 1; intr_type_i = 8'h41; boundary_i = 1;
        expect_none("R9 masked intr");
        flags_i = F_IF | F_TF; intr_i = 1; intr_type_i = 8'h41; boundary_i = 1;
        expect_entry("R9 R4 intr over step", 8'h41);
    endtask

    task automatic t_step();
        flags_i = F_TF | 16'h0080; boundary_i = 1;
        expect_entry("R10 single step", 8'd1);
        flags_i = 16'h0000; boundary_i = 1;
        expect_none("R11 no cause stays idle");
    endtask

    task automatic t_nmi();
        flags_i = 16'h0000;
        nmi_pin_i = 1; @(negedge clk);
        nmi_pin_i = 0; boundary_i = 1;
        expect_entry("R8 short pulse", 8'd2);
        nmi_pin_i = 1; @(negedge clk); @(negedge clk);
        flags_i = F_IF; intr_i = 1; intr_type_i = 8'h50; swi_req_i = 0; boundary_i = 1;
        expect_entry("R8 R4 nmi over intr", 8'd2);
        flags_i = 16'h0000; boundary_i = 1;
        expect_none("R8 held level no retrigger");
        nmi_pin_i = 0; @(negedge clk);
        nmi_pin_i = 1; @(negedge clk); @(negedge clk);
        swi_req_i = 1; swi_type_i = 8'h22; boundary_i = 1;
        expect_entry("R4 swi over nmi", 8'h22);
        boundary_i = 1;
        expect_entry("R8 nmi after swi", 8'd2);
        nmi_pin_i = 0; @(negedge clk);
    endtask

    task automatic t_coincide();
        flags_i = 16'h0000; nmi_pin_i = 1; div_err_i = 1; boundary_i = 1;
        expect_entry("R12 divide wins", 8'd0);
        boundary_i = 1;
        expect_entry("R12 nmi kept pending", 8'd2);
        nmi_pin_i = 0; @(negedge clk);
    endtask

    task automatic t_busy();
        flags_i = 16'h0000; cs_i = 16'h3333; ip_i = 16'h4444;
        swi_req_i = 1; swi_type_i = 8'h05; boundary_i = 1;
        @(posedge clk); @(negedge clk);
        clear_reqs();
        div_err_i = 1; boundary_i = 1; cs_i = 16'h9999;
        @(negedge clk);
        chk(push_valid_o && push_data_o == 16'h3333, "R11 cs push unchanged", push_data_o, 16'h3333);
        @(negedge clk);
        chk(push_valid_o && push_data_o == 16'h4444, "R11 ip push unchanged", push_data_o, 16'h4444);
        clear_reqs();
        @(negedge clk);
        chk(done_o && type_o == 8'h05, "R11 type unchanged", type_o, 8'h05);
        @(negedge clk);
        chk(!busy_o, "R11 idle after", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_divide();
        t_overflow();
        t_swi();
        t_intr();
        t_step();
        t_nmi();
        t_coincide();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule